// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives the card-side clock from the reference clock. Software programs a divider value and a clock-enable bit into holding registers. Those values do not affect the output clock when they are written. They reach the clock generator only when software issues a command with the start flag and the update-clock-only flag set. The block clears the start flag once it has applied the held values, and software polls that flag to learn that the change is complete.

A command may be told to wait until the data path reports idle before it is applied. A second start-flagged command written while one is still outstanding is refused, and a sticky hardware-locked error bit is raised. New settings are loaded only at the instant the divided clock is about to rise, or at any time while the clock is stopped. This keeps every high phase at full length.

The control FSM has three states:
- IDLE waits for a start flag.
- HOLD waits for the data path to go idle.
- SYNC waits for the generator's safe load point.

It has five transitions:
- IDLE→HOLD: the start flag is set, the wait flag is set and data is busy.
- IDLE→SYNC: the start flag is set, an update is requested and no wait is needed.
- HOLD→SYNC: data goes idle and an update is requested.
- HOLD→IDLE: data goes idle and no update is requested. The command completes.
- SYNC→IDLE: the generator loads the new values. The command completes.

A command without an update request completes straight from IDLE.

Top module: `ccd_card_clock`

## Requirements
- R1: After an applied update with divider value N (1..255, register address 0, bits 7:0) and enable 1, card_clk is high for N and low for N reference cycles, so its period is 2N.
- R2: An applied divider value of 0 makes card_clk toggle on every reference cycle (period 2).
- R3: Writes to the divider register (address 0) and the enable register (address 1, bit 0) read back at once but leave card_clk unchanged until an update command is applied.
- R4: Writing address 2 with bit 31 (start) set, while no command is pending, stores the command. Bit 31, bit 21 (update-clock-only) and bit 13 (wait-for-data) read back as written. Bit 31 reads 1 until the block has accepted the command, then the hardware clears it to 0.
- R5: Status bit 9 (address 3) mirrors data_busy. A command with bit 13 set is held, with bit 31 still 1 and the clock unchanged, for as long as data_busy stays high. It is applied after data_busy falls.
- R6: A command without bit 13 is applied even while data_busy is high.
- R7: A start command without bit 21 completes (bit 31 clears) and leaves the divider and enable in use unchanged.
- R8: A start-flagged command write while bit 31 is still 1 is discarded and sets status bit 12. Writing 1 to status bit 12 clears it.
- R9: With enable 0 applied, card_clk stays low. New settings are loaded only while card_clk is low, so every high phase lasts the full applied half period.
- R10: After reset, all registers read 0 and card_clk is low.
- R11: A write to address 2 with bit 31 clear starts nothing and leaves the command register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address (0 divider, 1 enable, 2 command, 3 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| data_busy | input | 1 | Data path busy indication |
| card_clk | output | 1 | Divided card clock |

## Verification
The bench builds the block with the default 8-bit divider field. It uses small divider values (0, 2, 3, 5) so that many full periods and every load point fit into short windows. The bench holds data_busy high across commands with and without the wait flag, which exercises the HOLD state and the refused second write. The clock output and the register read port are compared with a behavioural model on every cycle. A load at the wrong phase, or a missed or early start-flag clear, therefore shows up in the cycle where it happens.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
    typedef logic [1:0] reg_addr_t;

    localparam reg_addr_t ADR_DIV = 2'd0;
    localparam reg_addr_t ADR_ENA = 2'd1;
    localparam reg_addr_t ADR_CMD = 2'd2;
    localparam reg_addr_t ADR_STS = 2'd3;

    localparam int CMD_START_BIT = 31;
    localparam int CMD_UPD_BIT   = 21;
    localparam int CMD_WAIT_BIT  = 13;
    localparam int STS_BUSY_BIT  = 9;
    localparam int STS_LOCK_BIT  = 12;
    localparam int DATA_W        = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_SYNC = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/ccd_regs.sv
`timescale 1ns/1ps
module ccd_regs
    import ccd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_addr_t          wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  reg_addr_t          rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               data_busy,
    input  logic               cmd_done,
    output logic [DIV_W-1:0]   div_sh,
    output logic               en_sh,
    output logic               start_q,
    output logic               upd_q,
    output logic               wt_q,
    output logic               lock_q
);
    logic cmd_wr;
    logic cmd_accept;
    logic lock_set;
    logic lock_clr;
    logic unused_wdata;

    assign cmd_wr     = wr_en && (wr_addr == ADR_CMD) && wr_data[CMD_START_BIT];
    assign cmd_accept = cmd_wr && !start_q;
    assign lock_set   = cmd_wr && start_q;
    assign lock_clr   = wr_en && (wr_addr == ADR_STS) && wr_data[STS_LOCK_BIT];
    assign unused_wdata = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sh <= '0;
            en_sh  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_DIV) div_sh <= wr_data[DIV_W-1:0];
            if (wr_addr == ADR_ENA) en_sh  <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            upd_q   <= 1'b0;
            wt_q    <= 1'b0;
        end else if (cmd_accept) begin
            start_q <= 1'b1;
            upd_q   <= wr_data[CMD_UPD_BIT];
            wt_q    <= wr_data[CMD_WAIT_BIT];
        end else if (cmd_done) begin
            start_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lock_q <= 1'b0;
        else if (lock_set) lock_q <= 1'b1;
        else if (lock_clr) lock_q <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_DIV: rd_data[DIV_W-1:0] = div_sh;
            ADR_ENA: rd_data[0] = en_sh;
            ADR_CMD: begin
                rd_data[CMD_START_BIT] = start_q;
                rd_data[CMD_UPD_BIT]   = upd_q;
                rd_data[CMD_WAIT_BIT]  = wt_q;
            end
            default: begin
                rd_data[STS_BUSY_BIT] = data_busy;
                rd_data[STS_LOCK_BIT] = lock_q;
            end
        endcase
    end
endmodule

// File: rtl/ccd_ctrl.sv
`timescale 1ns/1ps
module ccd_ctrl
    import ccd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_q,
    input  logic        upd_q,
    input  logic        wt_q,
    input  logic        data_busy,
    input  logic        load_ack,
    output logic        cmd_done,
    output logic        load_req,
    output ctrl_state_t st
);
    ctrl_state_t st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx    = st;
        cmd_done = 1'b0;
        load_req = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_q) begin
                    if (wt_q && data_busy) st_nx = ST_HOLD;
                    else if (upd_q)        st_nx = ST_SYNC;
                    else                   cmd_done = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!data_busy) begin
                    if (upd_q) begin
                        st_nx = ST_SYNC;
                    end else begin
                        cmd_done = 1'b1;
                        st_nx    = ST_IDLE;
                    end
                end
            end
            ST_SYNC: begin
                load_req = 1'b1;
                if (load_ack) begin
                    cmd_done = 1'b1;
                    st_nx    = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ccd_clkgen.sv
`timescale 1ns/1ps
module ccd_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic [DIV_W-1:0] div_sh,
    input  logic             en_sh,
    output logic             load_ack,
    output logic             en_act,
    output logic             card_clk
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    logic [DIV_W-1:0] div_act;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_len;
    logic             phase_end;
    logic             safe;

    assign half_len  = (div_act == '0) ? ONE : div_act;
    assign phase_end = (cnt_q == half_len - ONE);
    assign safe      = !en_act || (!card_clk && phase_end);
    assign load_ack  = load_req && safe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_act  <= '0;
            en_act   <= 1'b0;
            cnt_q    <= '0;
            card_clk <= 1'b0;
        end else if (load_ack) begin
            div_act  <= div_sh;
            en_act   <= en_sh;
            cnt_q    <= '0;
            card_clk <= en_sh;
        end else if (!en_act) begin
            cnt_q    <= '0;
            card_clk <= 1'b0;
        end else if (phase_end) begin
            cnt_q    <= '0;
            card_clk <= !card_clk;
        end else begin
            cnt_q    <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/ccd_card_clock.sv
`timescale 1ns/1ps
module ccd_card_clock
    import ccd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        data_busy,
    output logic        card_clk
);
    logic [DIV_W-1:0] div_sh;
    logic             en_sh;
    logic             start_q;
    logic             upd_q;
    logic             wt_q;
    logic             lock_q;
    logic             cmd_done;
    logic             load_req;
    logic             load_ack;
    logic             en_act;
    ctrl_state_t      st;

    ccd_regs #(.DIV_W(DIV_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .data_busy(data_busy), .cmd_done(cmd_done), .div_sh(div_sh),
        .en_sh(en_sh), .start_q(start_q), .upd_q(upd_q), .wt_q(wt_q),
        .lock_q(lock_q)
    );

    ccd_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_q(start_q), .upd_q(upd_q),
        .wt_q(wt_q), .data_busy(data_busy), .load_ack(load_ack),
        .cmd_done(cmd_done), .load_req(load_req), .st(st)
    );

    ccd_clkgen #(.DIV_W(DIV_W)) i_gen (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .div_sh(div_sh),
        .en_sh(en_sh), .load_ack(load_ack), .en_act(en_act),
        .card_clk(card_clk)
    );
endmodule

// File: rtl/ccd_card_clock_chk.sv
`timescale 1ns/1ps
module ccd_card_clock_chk
    import ccd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        data_busy,
    input logic        start_q,
    input logic        lock_q,
    input logic        load_ack,
    input logic        en_act,
    input logic        card_clk,
    input ctrl_state_t st
);
    // R8
    lock_on_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CMD && wr_data[CMD_START_BIT] && start_q) |=> lock_q);

    // R5
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && data_busy) |=> start_q);

    // R9
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |-> !card_clk);

    // R9
    load_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |-> !card_clk);

    // R4
    start_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> $past(wr_en && wr_addr == ADR_CMD && wr_data[CMD_START_BIT]));

    // R11
    no_start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CMD && !wr_data[CMD_START_BIT] && !start_q) |=> !start_q);
endmodule

bind ccd_card_clock ccd_card_clock_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .data_busy(data_busy), .start_q(start_q),
    .lock_q(lock_q), .load_ack(load_ack), .en_act(en_act),
    .card_clk(card_clk), .st(st)
);

// File: tb/test_ccd_card_clock.sv
`timescale 1ns/1ps
module test_ccd_card_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        data_busy = 1'b0;
    logic        card_clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = !clk;

    ccd_card_clock i_ccd_card_clock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .data_busy(data_busy), .card_clk(card_clk)
    );

    // behavioural reference model
    int m_div, m_en, m_start, m_upd, m_wt, m_lock;
    int m_ph, m_a, m_e, m_cnt, m_q;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_en = 0; m_start = 0; m_upd = 0; m_wt = 0; m_lock = 0;
            m_ph = 0; m_a = 0; m_e = 0; m_cnt = 0; m_q = 0;
        end else begin
            int half, fin, ld, nph, nstart;
            half = (m_a == 0) ? 1 : m_a;
            ld = 0; fin = 0; nph = m_ph;
            if (m_ph == 0 && m_start != 0) begin
                if (m_wt != 0 && data_busy) nph = 1;
                else if (m_upd != 0) nph = 2;
                else fin = 1;
            end else if (m_ph == 1 && !data_busy) begin
                if (m_upd != 0) nph = 2;
                else begin fin = 1; nph = 0; end
            end else if (m_ph == 2) begin
                if (m_e == 0 || (m_q == 0 && m_cnt == half - 1)) begin
                    ld = 1; fin = 1; nph = 0;
                end
            end
            if (ld != 0) begin
                m_a = m_div; m_e = m_en; m_cnt = 0; m_q = m_en;
            end else if (m_e == 0) begin
                m_cnt = 0; m_q = 0;
            end else if (m_cnt == half - 1) begin
                m_cnt = 0; m_q = 1 - m_q;
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_ph = nph;
            nstart = (fin != 0) ? 0 : m_start;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_div = wr_data[7:0];
                    2'd1: m_en = wr_data[0];
                    2'd2: if (wr_data[31]) begin
                        if (m_start != 0) m_lock = 1;
                        else begin
                            nstart = 1; m_upd = wr_data[21]; m_wt = wr_data[13];
                        end
                    end
                    default: if (wr_data[12] && !(m_lock == 1 && 0)) m_lock = 0;
                endcase
            end
            m_start = nstart;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            2'd0: v[7:0] = m_div[7:0];
            2'd1: v[0] = m_en[0];
            2'd2: begin v[31] = m_start[0]; v[21] = m_upd[0]; v[13] = m_wt[0]; end
            default: begin v[9] = data_busy; v[12] = m_lock[0]; end
        endcase
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 card_clk vs model", card_clk, m_q);
            check("R4 rd_data vs model", rd_data, exp_rd(rd_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic wait_clear(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            rd(2'd2, v);
            n++;
        end while (v[31] && n < 2000);
        check(req, v[31], 0);
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        @(negedge clk);
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        while (card_clk) begin hi++; @(negedge clk); end
        while (!card_clk) begin lo++; @(negedge clk); end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hi, lo, highs;
        idle(3);
        #2 rst_n = 1'b1;

        // R10 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R10 reset register", v, 0);
        end
        check("R10 reset card_clk", card_clk, 0);

        // R3 shadow writes do not move the clock
        wr(2'd0, 32'd3);
        wr(2'd1, 32'd1);
        rd(2'd0, v); check("R3 divider readback", v, 3);
        highs = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (card_clk) highs++; end
        check("R3 clock unchanged before update", highs, 0);

        // R11 command write without start
        wr(2'd2, 32'h0020_2000);
        rd(2'd2, v); check("R11 command ignored", v, 0);

        // R4 start handshake, R1 period
        wr(2'd2, 32'h8020_0000);
        @(negedge clk);
        check("R4 start flag set after write", rd_data[31] || (rd_addr != 2'd2), 1);
        wait_clear("R4 start flag cleared");
        measure(hi, lo);
        check("R1 high length div 3", hi, 3);
        check("R1 low length div 3", lo, 3);

        // R2 divider zero
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h8020_0000);
        wait_clear("R2 update accepted");
        measure(hi, lo);
        check("R2 high length div 0", hi, 1);
        check("R2 low length div 0", lo, 1);

        // R5 wait for data idle
        data_busy = 1'b1;
        wr(2'd0, 32'd5);
        wr(2'd2, 32'h8020_2000);
        idle(30);
        rd(2'd2, v); check("R5 held while busy", v[31], 1);
        rd(2'd3, v); check("R5 busy status bit", v[9], 1);
        measure(hi, lo);
        check("R5 old period kept while held", hi, 1);
        @(posedge clk); #2 data_busy = 1'b0;
        wait_clear("R5 applied after busy falls");
        measure(hi, lo);
        check("R5 new period after busy", hi, 5);

        // R6 no wait flag: applied while busy
        data_busy = 1'b1;
        wr(2'd0, 32'd2);
        wr(2'd2, 32'h8020_0000);
        wait_clear("R6 applied while busy");
        measure(hi, lo);
        check("R6 high length div 2", hi, 2);
        check("R6 low length div 2", lo, 2);
        @(posedge clk); #2 data_busy = 1'b0;

        // R7 start without update
        wr(2'd0, 32'd7);
        wr(2'd2, 32'h8000_0000);
        wait_clear("R7 plain command completes");
        measure(hi, lo);
        check("R7 divider in use unchanged", hi, 2);

        // R8 refused second command
        data_busy = 1'b1;
        wr(2'd2, 32'h8020_2000);
        wr(2'd2, 32'h8000_0000);
        rd(2'd3, v); check("R8 lock bit set", v[12], 1);
        rd(2'd2, v); check("R8 first command kept", v, 32'h8020_2000);
        wr(2'd3, 32'h0000_1000);
        rd(2'd3, v); check("R8 lock bit cleared", v[12], 0);
        @(posedge clk); #2 data_busy = 1'b0;
        wait_clear("R8 first command completes");

        // R9 stop the clock
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h8020_0000);
        wait_clear("R9 stop accepted");
        highs = 0;
        for (int i = 0; i < 25; i++) begin @(negedge clk); if (card_clk) highs++; end
        check("R9 stopped clock stays low", highs, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule